// File: doc/BRIEF.md
# Integer Instruction Decoder

This block is a purely combinational decoder for a compact subset of a 32-bit Power-style integer instruction set. It takes one raw instruction word and a byte-order flag. From them it produces an internal operation code and a complete operand-routing description for the issue stage. The routing names up to three register read ports and one register write port. It also gives a decoded immediate, the record bit, the load/store access width and update flag, the branch link and absolute flags, and a special-register read select.

The supported forms are:
- register-register and register-immediate arithmetic and logical operations;
- indexed and displacement loads and stores;
- the register compare;
- the three rotate-with-mask operations;
- the unconditional, conditional and branch-to-register forms.

Operand routing depends on the opcode. Logical and rotate operations write the RA field and read RS through the third port. Stores read their source through the third port and write nothing. Any word outside the subset raises an illegal flag, and every enable stays low.

Field positions below use LSB-0 numbering on the 32-bit word after byte ordering:

| Field | Bits |
|---|---|
| primary opcode | [31:26] |
| RT/RS (also BO) | [25:21] |
| RA (also BI) | [20:16] |
| RB (also SH) | [15:11] |
| extended opcode | [10:1] |
| MB | [10:6] |
| ME | [5:1] |
| AA | [1] |
| Rc/LK | [0] |
| 16-bit immediate | [15:0] |

Top module: `pw_insn_decoder`

## Requirements
- R1: The operation code is: 0 none, 1 ADD, 2 AND, 3 OR, 4 LOAD, 5 STORE, 6 COMPARE, 7 ROTATE, 8 BRANCH. Primary opcode 31 uses these extended opcodes: 266 add, 28 and, 444 or, 23 lwzx, 151 stwx, 0 cmp. The other primary opcodes are: addi 14, addis 15, andi. 28, ori 24, lwz 32, lwzu 33, lbz 34, lhz 40, stw 36, stwu 37, stb 38, sth 44, rlwimi 20, rlwinm 21, rlwnm 23, b 18, bc 16. Primary opcode 19 gives bclr with extended opcode 16 and bcctr with extended opcode 528. All the branch forms map to BRANCH.
- R2: With big_end_i=1 the word is decoded as given. With big_end_i=0 its four bytes are reversed before decoding.
- R3: add, addi, addis and all loads write RT (wr_en=1), and present RA on read port 1. add and lwzx also present RB on read port 2.
- R4: Stores present RS on read port 3 and RA on read port 1, and wr_en stays 0. stwx also presents RB on read port 2.
- R5: and, or, andi., ori and the rotates write RA and present RS on read port 3, with read port 1 disabled. and and or also present RB on read port 2.
- R6: addi and the displacement loads and stores sign-extend the 16-bit immediate. andi. and ori zero-extend it. addis places it in bits [31:16] with zero low half. imm_en is set for these forms.
- R7: rc_o equals bit [0] for add, and, or and the rotates. It is forced to 1 for andi. and is 0 for every other instruction.
- R8: ldst_len_o is 4 for word, 2 for halfword and 1 for byte accesses, and 0 for non-memory operations. update_o is 1 only for lwzu and stwu.
- R9: cmp presents RA on port 1 and RB on port 2, with no write. bf_o carries bits [25:23]. cmp with bit [21] (the 64-bit flag) set is illegal.
- R10: sh_o, mb_o and me_o carry bits [15:11], [10:6] and [5:1]. rlwnm also presents RB on read port 2, while rlwinm and rlwimi leave port 2 disabled.
- R11: b uses the displacement {bits[25:2],00} and bc uses {bits[15:2],00}, each sign-extended to 32 bits, with imm_en set. aa_o is bit [1] and lk_o is bit [0]. bo_o and bi_o carry bits [25:21] and [20:16].
- R12: bclr and bcctr set spr_en_o, with spr_sel_o 0 for the link register and 1 for the count register. lk_o is bit [0], and no immediate is driven.
- R13: Any unsupported word sets illegal_o. It forces op_o to 0 and holds low every enable, rc_o, lk_o, aa_o, update_o and ldst_len_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Raw instruction word |
| big_end_i | input | 1 | 1: word used as given, 0: bytes reversed first |
| illegal_o | output | 1 | Word outside supported subset |
| op_o | output | 4 | Internal operation code |
| rd1_en_o | output | 1 | Read port 1 used |
| rd1_sel_o | output | 5 | Read port 1 register number |
| rd2_en_o | output | 1 | Read port 2 used |
| rd2_sel_o | output | 5 | Read port 2 register number |
| rd3_en_o | output | 1 | Read port 3 used |
| rd3_sel_o | output | 5 | Read port 3 register number |
| wr_en_o | output | 1 | Write port used |
| wr_sel_o | output | 5 | Write register number |
| imm_en_o | output | 1 | Immediate operand valid |
| imm_o | output | 32 | Decoded immediate |
| rc_o | output | 1 | Record condition bit |
| ldst_len_o | output | 4 | Memory access size in bytes |
| update_o | output | 1 | Base register update variant |
| lk_o | output | 1 | Branch writes link register |
| aa_o | output | 1 | Branch target is absolute |
| spr_en_o | output | 1 | Special register read used |
| spr_sel_o | output | 1 | 0 link register, 1 count register |
| bo_o | output | 5 | Branch options field |
| bi_o | output | 5 | Branch condition bit index |
| bf_o | output | 3 | Compare target field index |
| sh_o | output | 5 | Rotate shift field |
| mb_o | output | 5 | Mask begin field |
| me_o | output | 5 | Mask end field |

## Verification
On every input change the assertions check several relationships between outputs:
- an illegal word leaves every enable quiet;
- a store never enables the write port;
- update, access length and special-register select appear only with the matching operation;
- branch displacements are word aligned.

Only the directed scenarios can show the rest: that each specific encoding lands on the right operation, that the right register field reaches the right port, the immediate extension and shift values, and that byte reversal under the little-endian setting yields the same decode.

// File: rtl/pw_dec_pkg.sv
package pw_dec_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int REG_W   = 5;
    localparam int PO_W    = 6;
    localparam int XO_W    = 10;
    localparam int IMM16_W = 16;
    localparam int LEN_W   = 4;

    typedef enum logic [3:0] {
        OP_NONE   = 4'd0,
        OP_ADD    = 4'd1,
        OP_AND    = 4'd2,
        OP_OR     = 4'd3,
        OP_LOAD   = 4'd4,
        OP_STORE  = 4'd5,
        OP_CMP    = 4'd6,
        OP_ROTATE = 4'd7,
        OP_BRANCH = 4'd8
    } op_e;

    typedef enum logic [3:0] {
        K_ILL, K_ADD_X, K_LOGIC_X, K_LD_X, K_ST_X, K_CMP,
        K_ADDI, K_ADDIS, K_LOGIC_I, K_LD_D, K_ST_D,
        K_ROT_I, K_ROT_R, K_BR_I, K_BR_B, K_BR_R
    } kind_e;

    typedef struct packed {
        logic [PO_W-1:0]    po;
        logic [REG_W-1:0]   rt;
        logic [REG_W-1:0]   ra;
        logic [REG_W-1:0]   rb;
        logic [XO_W-1:0]    xo;
        logic [REG_W-1:0]   mb;
        logic [REG_W-1:0]   me;
        logic               aa;
        logic               lsb;
        logic               wide;
        logic [IMM16_W-1:0] d16;
        logic [23:0]        li;
        logic [13:0]        bd;
    } fields_t;

    typedef struct packed {
        kind_e             kind;
        op_e               op;
        logic [LEN_W-1:0]  len;
        logic              upd;
        logic              rc_bit;
        logic              rc_force;
        logic              spr_ctr;
    } cls_t;

    function automatic fields_t split_fields(input logic [WORD_W-1:0] w);
        fields_t f;
        f.po   = w[31:26];
        f.rt   = w[25:21];
        f.ra   = w[20:16];
        f.rb   = w[15:11];
        f.xo   = w[10:1];
        f.mb   = w[10:6];
        f.me   = w[5:1];
        f.aa   = w[1];
        f.lsb  = w[0];
        f.wide = w[21];
        f.d16  = w[15:0];
        f.li   = w[25:2];
        f.bd   = w[15:2];
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] sext16(input logic [IMM16_W-1:0] v);
        return {{(WORD_W-IMM16_W){v[IMM16_W-1]}}, v};
    endfunction

endpackage

// File: rtl/pw_byte_order.sv
module pw_byte_order
    import pw_dec_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int BW = BYTE_W
) (
    input  logic [W-1:0] word_i,
    input  logic         as_is_i,
    output logic [W-1:0] word_o
);
    localparam int NB = W / BW;

    logic [W-1:0] rev;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign rev[b*BW +: BW] = word_i[(NB-1-b)*BW +: BW];
    end

    assign word_o = as_is_i ? word_i : rev;
endmodule

// File: rtl/pw_insn_classify.sv
module pw_insn_classify
    import pw_dec_pkg::*;
(
    input  fields_t f_i,
    output cls_t    cls_o
);
    always_comb begin
        cls_o = '{kind: K_ILL, op: OP_NONE, len: '0, upd: 1'b0,
                  rc_bit: 1'b0, rc_force: 1'b0, spr_ctr: 1'b0};
        unique case (f_i.po)
            6'd31: begin
                unique case (f_i.xo)
                    10'd266: begin cls_o.kind = K_ADD_X;   cls_o.op = OP_ADD; cls_o.rc_bit = 1'b1; end
                    10'd28:  begin cls_o.kind = K_LOGIC_X; cls_o.op = OP_AND; cls_o.rc_bit = 1'b1; end
                    10'd444: begin cls_o.kind = K_LOGIC_X; cls_o.op = OP_OR;  cls_o.rc_bit = 1'b1; end
                    10'd23:  begin cls_o.kind = K_LD_X; cls_o.op = OP_LOAD;  cls_o.len = 4'd4; end
                    10'd151: begin cls_o.kind = K_ST_X; cls_o.op = OP_STORE; cls_o.len = 4'd4; end
                    10'd0: begin
                        if (!f_i.wide) begin
                            cls_o.kind = K_CMP;
                            cls_o.op   = OP_CMP;
                        end
                    end
                    default: ;
                endcase
            end
            6'd14: begin cls_o.kind = K_ADDI;    cls_o.op = OP_ADD; end
            6'd15: begin cls_o.kind = K_ADDIS;   cls_o.op = OP_ADD; end
            6'd28: begin cls_o.kind = K_LOGIC_I; cls_o.op = OP_AND; cls_o.rc_force = 1'b1; end
            6'd24: begin cls_o.kind = K_LOGIC_I; cls_o.op = OP_OR; end
            6'd32: begin cls_o.kind = K_LD_D; cls_o.op = OP_LOAD;  cls_o.len = 4'd4; end
            6'd33: begin cls_o.kind = K_LD_D; cls_o.op = OP_LOAD;  cls_o.len = 4'd4; cls_o.upd = 1'b1; end
            6'd34: begin cls_o.kind = K_LD_D; cls_o.op = OP_LOAD;  cls_o.len = 4'd1; end
            6'd40: begin cls_o.kind = K_LD_D; cls_o.op = OP_LOAD;  cls_o.len = 4'd2; end
            6'd36: begin cls_o.kind = K_ST_D; cls_o.op = OP_STORE; cls_o.len = 4'd4; end
            6'd37: begin cls_o.kind = K_ST_D; cls_o.op = OP_STORE; cls_o.len = 4'd4; cls_o.upd = 1'b1; end
            6'd38: begin cls_o.kind = K_ST_D; cls_o.op = OP_STORE; cls_o.len = 4'd1; end
            6'd44: begin cls_o.kind = K_ST_D; cls_o.op = OP_STORE; cls_o.len = 4'd2; end
            6'd20, 6'd21: begin cls_o.kind = K_ROT_I; cls_o.op = OP_ROTATE; cls_o.rc_bit = 1'b1; end
            6'd23: begin cls_o.kind = K_ROT_R; cls_o.op = OP_ROTATE; cls_o.rc_bit = 1'b1; end
            6'd18: begin cls_o.kind = K_BR_I; cls_o.op = OP_BRANCH; end
            6'd16: begin cls_o.kind = K_BR_B; cls_o.op = OP_BRANCH; end
            6'd19: begin
                if (f_i.xo == 10'd16) begin
                    cls_o.kind = K_BR_R; cls_o.op = OP_BRANCH;
                end else if (f_i.xo == 10'd528) begin
                    cls_o.kind = K_BR_R; cls_o.op = OP_BRANCH; cls_o.spr_ctr = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pw_operand_route.sv
module pw_operand_route
    import pw_dec_pkg::*;
(
    input  fields_t            f_i,
    input  cls_t               cls_i,
    output logic               rd1_en_o,
    output logic [REG_W-1:0]   rd1_sel_o,
    output logic               rd2_en_o,
    output logic [REG_W-1:0]   rd2_sel_o,
    output logic               rd3_en_o,
    output logic [REG_W-1:0]   rd3_sel_o,
    output logic               wr_en_o,
    output logic [REG_W-1:0]   wr_sel_o,
    output logic               imm_en_o,
    output logic [WORD_W-1:0]  imm_o,
    output logic               aa_o,
    output logic               lk_o,
    output logic               spr_en_o
);
    always_comb begin
        rd1_en_o = 1'b0; rd1_sel_o = '0;
        rd2_en_o = 1'b0; rd2_sel_o = '0;
        rd3_en_o = 1'b0; rd3_sel_o = '0;
        wr_en_o  = 1'b0; wr_sel_o  = '0;
        imm_en_o = 1'b0; imm_o     = '0;
        aa_o     = 1'b0; lk_o      = 1'b0;
        spr_en_o = 1'b0;
        unique case (cls_i.kind)
            K_ADD_X, K_LD_X: begin
                wr_en_o  = 1'b1; wr_sel_o  = f_i.rt;
                rd1_en_o = 1'b1; rd1_sel_o = f_i.ra;
                rd2_en_o = 1'b1; rd2_sel_o = f_i.rb;
            end
            K_LOGIC_X: begin
                wr_en_o  = 1'b1; wr_sel_o  = f_i.ra;
                rd3_en_o = 1'b1; rd3_sel_o = f_i.rt;
                rd2_en_o = 1'b1; rd2_sel_o = f_i.rb;
            end
            K_ST_X: begin
                rd3_en_o = 1'b1; rd3_sel_o = f_i.rt;
                rd1_en_o = 1'b1; rd1_sel_o = f_i.ra;
                rd2_en_o = 1'b1; rd2_sel_o = f_i.rb;
            end
            K_CMP: begin
                rd1_en_o = 1'b1; rd1_sel_o = f_i.ra;
                rd2_en_o = 1'b1; rd2_sel_o = f_i.rb;
            end
            K_ADDI, K_LD_D: begin
                wr_en_o  = 1'b1; wr_sel_o  = f_i.rt;
                rd1_en_o = 1'b1; rd1_sel_o = f_i.ra;
                imm_en_o = 1'b1; imm_o     = sext16(f_i.d16);
            end
            K_ADDIS: begin
                wr_en_o  = 1'b1; wr_sel_o  = f_i.rt;
                rd1_en_o = 1'b1; rd1_sel_o = f_i.ra;
                imm_en_o = 1'b1; imm_o     = {f_i.d16, {IMM16_W{1'b0}}};
            end
            K_LOGIC_I: begin
                wr_en_o  = 1'b1; wr_sel_o  = f_i.ra;
                rd3_en_o = 1'b1; rd3_sel_o = f_i.rt;
                imm_en_o = 1'b1; imm_o     = {{(WORD_W-IMM16_W){1'b0}}, f_i.d16};
            end
            K_ST_D: begin
                rd3_en_o = 1'b1; rd3_sel_o = f_i.rt;
                rd1_en_o = 1'b1; rd1_sel_o = f_i.ra;
                imm_en_o = 1'b1; imm_o     = sext16(f_i.d16);
            end
            K_ROT_I, K_ROT_R: begin
                wr_en_o  = 1'b1; wr_sel_o  = f_i.ra;
                rd3_en_o = 1'b1; rd3_sel_o = f_i.rt;
                if (cls_i.kind == K_ROT_R) begin
                    rd2_en_o = 1'b1; rd2_sel_o = f_i.rb;
                end
            end
            K_BR_I: begin
                imm_en_o = 1'b1;
                imm_o    = {{(WORD_W-26){f_i.li[23]}}, f_i.li, 2'b00};
                aa_o     = f_i.aa; lk_o = f_i.lsb;
            end
            K_BR_B: begin
                imm_en_o = 1'b1;
                imm_o    = {{(WORD_W-16){f_i.bd[13]}}, f_i.bd, 2'b00};
                aa_o     = f_i.aa; lk_o = f_i.lsb;
            end
            K_BR_R: begin
                spr_en_o = 1'b1;
                lk_o     = f_i.lsb;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pw_insn_decoder.sv
module pw_insn_decoder
    import pw_dec_pkg::*;
(
    input  logic [31:0] insn_i,
    input  logic        big_end_i,
    output logic        illegal_o,
    output logic [3:0]  op_o,
    output logic        rd1_en_o,
    output logic [4:0]  rd1_sel_o,
    output logic        rd2_en_o,
    output logic [4:0]  rd2_sel_o,
    output logic        rd3_en_o,
    output logic [4:0]  rd3_sel_o,
    output logic        wr_en_o,
    output logic [4:0]  wr_sel_o,
    output logic        imm_en_o,
    output logic [31:0] imm_o,
    output logic        rc_o,
    output logic [3:0]  ldst_len_o,
    output logic        update_o,
    output logic        lk_o,
    output logic        aa_o,
    output logic        spr_en_o,
    output logic        spr_sel_o,
    output logic [4:0]  bo_o,
    output logic [4:0]  bi_o,
    output logic [2:0]  bf_o,
    output logic [4:0]  sh_o,
    output logic [4:0]  mb_o,
    output logic [4:0]  me_o
);
    logic [WORD_W-1:0] word;
    fields_t           fld;
    cls_t              cls;

    pw_byte_order #(.W(WORD_W), .BW(BYTE_W)) u_order (
        .word_i (insn_i),
        .as_is_i(big_end_i),
        .word_o (word)
    );

    assign fld = split_fields(word);

    pw_insn_classify u_cls (
        .f_i  (fld),
        .cls_o(cls)
    );

    pw_operand_route u_route (
        .f_i      (fld),
        .cls_i    (cls),
        .rd1_en_o (rd1_en_o),
        .rd1_sel_o(rd1_sel_o),
        .rd2_en_o (rd2_en_o),
        .rd2_sel_o(rd2_sel_o),
        .rd3_en_o (rd3_en_o),
        .rd3_sel_o(rd3_sel_o),
        .wr_en_o  (wr_en_o),
        .wr_sel_o (wr_sel_o),
        .imm_en_o (imm_en_o),
        .imm_o    (imm_o),
        .aa_o     (aa_o),
        .lk_o     (lk_o),
        .spr_en_o (spr_en_o)
    );

    assign illegal_o  = (cls.kind == K_ILL);
    assign op_o       = cls.op;
    assign rc_o       = (cls.rc_bit & fld.lsb) | cls.rc_force;
    assign ldst_len_o = cls.len;
    assign update_o   = cls.upd;
    assign spr_sel_o  = cls.spr_ctr;
    assign bo_o       = fld.rt;
    assign bi_o       = fld.ra;
    assign bf_o       = fld.rt[4:2];
    assign sh_o       = fld.rb;
    assign mb_o       = fld.mb;
    assign me_o       = fld.me;
endmodule

// File: rtl/pw_insn_decoder_chk.sv
module pw_insn_decoder_chk (
    input logic        illegal_o,
    input logic [3:0]  op_o,
    input logic        rd1_en_o,
    input logic        rd2_en_o,
    input logic        rd3_en_o,
    input logic        wr_en_o,
    input logic        imm_en_o,
    input logic [31:0] imm_o,
    input logic        rc_o,
    input logic [3:0]  ldst_len_o,
    input logic        update_o,
    input logic        lk_o,
    input logic        aa_o,
    input logic        spr_en_o
);
    always_comb begin
        if (illegal_o) begin
            assert_illegal_quiet_R13: assert (op_o == 4'd0 && !rd1_en_o && !rd2_en_o
                && !rd3_en_o && !wr_en_o && !imm_en_o && !rc_o && !lk_o && !aa_o
                && !update_o && !spr_en_o && ldst_len_o == 4'd0);
        end
        if (op_o == 4'd5) begin
            assert_store_no_write_R4: assert (!wr_en_o && rd3_en_o && rd1_en_o);
        end
        if (update_o) begin
            assert_update_memop_R8: assert ((op_o == 4'd4 || op_o == 4'd5) && ldst_len_o == 4'd4);
        end
        assert_len_memop_R8: assert ((ldst_len_o != 4'd0) == (op_o == 4'd4 || op_o == 4'd5));
        if (op_o == 4'd8 && imm_en_o) begin
            assert_branch_aligned_R11: assert (imm_o[1:0] == 2'b00 && !spr_en_o);
        end
        if (spr_en_o) begin
            assert_spr_branch_R12: assert (op_o == 4'd8 && !imm_en_o);
        end
        if (lk_o || aa_o) begin
            assert_link_branch_R11: assert (op_o == 4'd8);
        end
    end
endmodule

bind pw_insn_decoder pw_insn_decoder_chk u_chk (.*);

// File: tb/pw_insn_decoder_test.sv
module pw_insn_decoder_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [31:0] insn;
    logic        big_end;
    logic        illegal, rd1_en, rd2_en, rd3_en, wr_en, imm_en, rc, update, lk, aa, spr_en, spr_sel;
    logic [3:0]  op, ldst_len;
    logic [4:0]  rd1_sel, rd2_sel, rd3_sel, wr_sel, bo, bi, sh, mb, me;
    logic [2:0]  bf;
    logic [31:0] imm;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    pw_insn_decoder uut (
        .insn_i(insn), .big_end_i(big_end), .illegal_o(illegal), .op_o(op),
        .rd1_en_o(rd1_en), .rd1_sel_o(rd1_sel), .rd2_en_o(rd2_en), .rd2_sel_o(rd2_sel),
        .rd3_en_o(rd3_en), .rd3_sel_o(rd3_sel), .wr_en_o(wr_en), .wr_sel_o(wr_sel),
        .imm_en_o(imm_en), .imm_o(imm), .rc_o(rc), .ldst_len_o(ldst_len),
        .update_o(update), .lk_o(lk), .aa_o(aa), .spr_en_o(spr_en), .spr_sel_o(spr_sel),
        .bo_o(bo), .bi_o(bi), .bf_o(bf), .sh_o(sh), .mb_o(mb), .me_o(me)
    );

    function automatic logic [31:0] enc_x(int po, int rt, int ra, int rb, int xo, int r);
        return {po[5:0], rt[4:0], ra[4:0], rb[4:0], xo[9:0], r[0]};
    endfunction
    function automatic logic [31:0] enc_d(int po, int rt, int ra, int d);
        return {po[5:0], rt[4:0], ra[4:0], d[15:0]};
    endfunction
    function automatic logic [31:0] enc_m(int po, int rs, int ra, int s, int b, int e, int r);
        return {po[5:0], rs[4:0], ra[4:0], s[4:0], b[4:0], e[4:0], r[0]};
    endfunction
    function automatic logic [31:0] swap32(logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] w, logic be);
        @(negedge clk);
        insn = w; big_end = be;
        #1;
    endtask

    task automatic t_idle;
        apply(32'h0, 1'b1);
        chk("R13", "zero word illegal", illegal, 1);
        chk("R13", "zero word op", op, 0);
        chk("R13", "zero word enables", {rd1_en, rd2_en, rd3_en, wr_en, imm_en, spr_en}, 0);
    endtask

    task automatic t_regreg;
        apply(enc_x(31, 3, 4, 5, 266, 0), 1'b1);
        chk("R1", "add op", op, 1);
        chk("R3", "add ports", {wr_en, wr_sel, rd1_en, rd1_sel, rd2_en, rd2_sel, rd3_en},
            {1'b1, 5'd3, 1'b1, 5'd4, 1'b1, 5'd5, 1'b0});
        chk("R7", "add rc", rc, 0);
        apply(enc_x(31, 3, 4, 5, 266, 1), 1'b1);
        chk("R7", "add. rc", rc, 1);
        apply(enc_x(31, 8, 7, 9, 28, 1), 1'b1);
        chk("R1", "and op", op, 2);
        chk("R5", "and ports", {wr_en, wr_sel, rd1_en, rd3_en, rd3_sel, rd2_en, rd2_sel},
            {1'b1, 5'd7, 1'b0, 1'b1, 5'd8, 1'b1, 5'd9});
        chk("R7", "and. rc", rc, 1);
        apply(enc_x(31, 30, 31, 1, 444, 0), 1'b1);
        chk("R1", "or op", op, 3);
        chk("R5", "or ports", {wr_sel, rd3_sel, rd2_sel}, {5'd31, 5'd30, 5'd1});
    endtask

    task automatic t_imm;
        apply(enc_d(14, 2, 6, 16'h8000), 1'b1);
        chk("R1", "addi op", op, 1);
        chk("R6", "addi imm", {imm_en, imm}, {1'b1, 32'hFFFF8000});
        chk("R3", "addi ports", {wr_sel, rd1_en, rd1_sel}, {5'd2, 1'b1, 5'd6});
        apply(enc_d(15, 2, 6, 16'h1234), 1'b1);
        chk("R6", "addis imm", imm, 32'h12340000);
        apply(enc_d(28, 10, 11, 16'h8001), 1'b1);
        chk("R1", "andi. op", op, 2);
        chk("R6", "andi. imm", imm, 32'h00008001);
        chk("R5", "andi. ports", {wr_sel, rd3_en, rd3_sel, rd1_en}, {5'd11, 1'b1, 5'd10, 1'b0});
        chk("R7", "andi. rc", rc, 1);
        apply(enc_d(24, 10, 11, 16'hFFFF), 1'b1);
        chk("R6", "ori imm", imm, 32'h0000FFFF);
        chk("R7", "ori rc", rc, 0);
    endtask

    task automatic t_ldst;
        apply(enc_d(32, 12, 13, 16'h0040), 1'b1);
        chk("R1", "lwz op", op, 4);
        chk("R3", "lwz ports", {wr_en, wr_sel, rd1_sel, rd3_en}, {1'b1, 5'd12, 5'd13, 1'b0});
        chk("R8", "lwz len/upd", {ldst_len, update}, {4'd4, 1'b0});
        apply(enc_d(33, 12, 13, 16'hFFF0), 1'b1);
        chk("R8", "lwzu len/upd", {ldst_len, update}, {4'd4, 1'b1});
        chk("R6", "lwzu imm", imm, 32'hFFFFFFF0);
        apply(enc_d(34, 1, 2, 4), 1'b1);
        chk("R8", "lbz len", ldst_len, 1);
        apply(enc_d(40, 1, 2, 4), 1'b1);
        chk("R8", "lhz len", ldst_len, 2);
        apply(enc_d(36, 20, 21, 8), 1'b1);
        chk("R1", "stw op", op, 5);
        chk("R4", "stw ports", {wr_en, rd3_en, rd3_sel, rd1_sel}, {1'b0, 1'b1, 5'd20, 5'd21});
        apply(enc_d(37, 20, 21, 8), 1'b1);
        chk("R8", "stwu upd", {ldst_len, update}, {4'd4, 1'b1});
        apply(enc_d(38, 20, 21, 8), 1'b1);
        chk("R8", "stb len", {ldst_len, update}, {4'd1, 1'b0});
        apply(enc_d(44, 20, 21, 8), 1'b1);
        chk("R8", "sth len", ldst_len, 2);
        apply(enc_x(31, 5, 6, 7, 23, 0), 1'b1);
        chk("R3", "lwzx ports", {op, wr_sel, rd1_sel, rd2_en, rd2_sel}, {4'd4, 5'd5, 5'd6, 1'b1, 5'd7});
        apply(enc_x(31, 5, 6, 7, 151, 0), 1'b1);
        chk("R4", "stwx ports", {op, wr_en, rd3_sel, rd1_sel, rd2_sel}, {4'd5, 1'b0, 5'd5, 5'd6, 5'd7});
    endtask

    task automatic t_cmp;
        apply(enc_x(31, 5 << 2, 14, 15, 0, 0), 1'b1);
        chk("R1", "cmp op", op, 6);
        chk("R9", "cmp ports", {rd1_en, rd1_sel, rd2_en, rd2_sel, wr_en}, {1'b1, 5'd14, 1'b1, 5'd15, 1'b0});
        chk("R9", "cmp bf", bf, 5);
        apply(enc_x(31, (5 << 2) | 1, 14, 15, 0, 0), 1'b1);
        chk("R9", "cmp wide illegal", illegal, 1);
    endtask

    task automatic t_rot;
        apply(enc_m(21, 3, 9, 17, 4, 27, 1), 1'b1);
        chk("R1", "rlwinm op", op, 7);
        chk("R10", "rlwinm fields", {sh, mb, me}, {5'd17, 5'd4, 5'd27});
        chk("R5", "rlwinm ports", {wr_sel, rd3_sel, rd2_en, rd1_en}, {5'd9, 5'd3, 1'b0, 1'b0});
        chk("R7", "rlwinm. rc", rc, 1);
        apply(enc_m(23, 3, 9, 17, 0, 31, 0), 1'b1);
        chk("R10", "rlwnm rb port", {rd2_en, rd2_sel, rc}, {1'b1, 5'd17, 1'b0});
        apply(enc_m(20, 3, 9, 2, 1, 30, 0), 1'b1);
        chk("R10", "rlwimi", {op, rd2_en, sh, mb, me}, {4'd7, 1'b0, 5'd2, 5'd1, 5'd30});
    endtask

    task automatic t_branch;
        apply({6'd18, 24'h800001, 1'b0, 1'b1}, 1'b1);
        chk("R1", "bl op", op, 8);
        chk("R11", "bl disp", {imm_en, imm}, {1'b1, 32'hFE000004});
        chk("R11", "bl lk/aa", {lk, aa}, 2'b10);
        apply({6'd18, 24'h000100, 1'b1, 1'b0}, 1'b1);
        chk("R11", "ba", {imm, lk, aa}, {32'h00000400, 1'b0, 1'b1});
        apply({6'd16, 5'd12, 5'd29, 14'h2001, 1'b1, 1'b1}, 1'b1);
        chk("R11", "bcla disp", imm, 32'hFFFF8004);
        chk("R11", "bcla flags", {bo, bi, lk, aa}, {5'd12, 5'd29, 1'b1, 1'b1});
        apply({6'd19, 5'd20, 5'd3, 5'd0, 10'd16, 1'b0}, 1'b1);
        chk("R12", "bclr", {op, spr_en, spr_sel, lk, imm_en}, {4'd8, 1'b1, 1'b0, 1'b0, 1'b0});
        chk("R11", "bclr bo/bi", {bo, bi}, {5'd20, 5'd3});
        apply({6'd19, 5'd4, 5'd7, 5'd0, 10'd528, 1'b1}, 1'b1);
        chk("R12", "bcctrl", {spr_en, spr_sel, lk}, 3'b111);
    endtask

    task automatic t_order;
        logic [31:0] w;
        w = enc_x(31, 3, 4, 5, 266, 1);
        apply(swap32(w), 1'b0);
        chk("R2", "swapped add", {op, wr_sel, rd1_sel, rd2_sel, rc}, {4'd1, 5'd3, 5'd4, 5'd5, 1'b1});
        apply(w, 1'b0);
        chk("R2", "unswapped under LE", illegal, 1);
    endtask

    task automatic t_illegal;
        apply(enc_x(31, 1, 2, 3, 999, 1), 1'b1);
        chk("R13", "bad xo", {illegal, op, wr_en, rc}, {1'b1, 4'd0, 1'b0, 1'b0});
        apply({6'd19, 5'd1, 5'd2, 5'd0, 10'd50, 1'b1}, 1'b1);
        chk("R13", "bad xl", {illegal, spr_en, lk}, {1'b1, 1'b0, 1'b0});
        apply(enc_d(1, 1, 2, 3), 1'b1);
        chk("R13", "bad po", {illegal, rd1_en, imm_en, ldst_len}, {1'b1, 1'b0, 1'b0, 4'd0});
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        insn = 32'h0; big_end = 1'b1;
        t_idle();
        t_regreg();
        t_imm();
        t_ldst();
        t_cmp();
        t_rot();
        t_branch();
        t_order();
        t_illegal();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule